// File: doc/BRIEF.md
# Pipelined SIMD Lane Multiplier

This block multiplies packed integer and fixed-point elements within one 64-bit vector lane. A two-bit width code selects the packing. The lane holds one 64-bit element, two 32-bit elements, four 16-bit elements or eight 8-bit elements. Each element is computed from its own full double-width product. Three operands (`a`, `b`, `c`) enter together with a per-byte mask, a four-bit operation code and a two-bit rounding mode.

The operations are:
- a low-half multiply;
- three high-half multiplies, one for each signedness combination;
- four multiply-accumulate forms, which add the product or subtract it and use either `c` or `b` as the addend;
- a rounded, saturating fractional multiply.

The result, the mask and a per-byte saturation vector pass through `STAGES` register stages. Each stage has valid/ready flow control. When the consumer never stalls, the block accepts one operation and delivers one result per cycle.

Top module: `simd_lane_mul`

## Requirements
- R1: `ew_i` selects the packing: 0 gives eight 8-bit elements, 1 gives four 16-bit elements, 2 gives two 32-bit elements and 3 gives one 64-bit element. Element k occupies bits [k*W +: W] of every operand and of the result, and elements never interact.
- R2: Op 0 returns the low W bits of a×b for each element.
- R3: Op 1 returns the upper W bits of the signed×signed product. Op 2 returns the upper W bits of the unsigned×unsigned product. Op 3 returns the upper W bits of the product of a signed `a` and an unsigned `b`.
- R4: Op 4 returns c + a×b and op 6 returns c − a×b, each taken modulo 2^W.
- R5: Op 5 returns b + a×c and op 7 returns b − a×c, each taken modulo 2^W. In these forms `b` and `c` swap roles.
- R6: Op 8 forms the signed product and shifts it right by W−1. It then adds a rounding increment chosen by `rm_i`. Mode 0 rounds to nearest with ties up. Mode 1 rounds to nearest with ties to even. Mode 2 truncates. Mode 3 sets the result LSB when any discarded bit is set (round to odd).
- R7: For op 8, an element whose two operands both equal the most negative value gives the most positive value. The block then sets `sat_o` on every byte of that element where `mask_i` is set. `sat_o` is zero for every other case, every other op and every unmasked byte.
- R8: `mask_o` presents the `mask_i` value that was accepted with the same operation.
- R9: An operation accepted while `ready_i` stays high appears on `valid_o` exactly `STAGES` cycles later. Back-to-back operations stream at one per cycle.
- R10: While `valid_o` is high and `ready_i` is low, all outputs hold. Every accepted operation is delivered exactly once, in order. `ready_o` is high whenever the output stage is empty.
- R11: While `rst_ni` is low, `valid_o` is low and no pipeline stage holds valid data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | Operand a (multiplicand) |
| b_i | input | 64 | Operand b |
| c_i | input | 64 | Operand c |
| mask_i | input | 8 | Per-byte mask |
| op_i | input | 4 | Operation code (0..8) |
| ew_i | input | 2 | Element width code |
| rm_i | input | 2 | Rounding mode for op 8 |
| valid_i | input | 1 | Input operation valid |
| ready_o | output | 1 | Block can accept an operation |
| result_o | output | 64 | Packed result |
| mask_o | output | 8 | Forwarded mask |
| sat_o | output | 8 | Per-byte saturation flags |
| valid_o | output | 1 | Output valid |
| ready_i | input | 1 | Consumer accepts the output |

## Verification
The hold assertions assume that a consumer which has lowered `ready_i` does not expect the output to change. They also assume that `valid_i` and the operand inputs are settled before each rising edge. The bench drives all inputs half a cycle away from that edge, so both assumptions hold.

Opcodes above 8 are undefined, and the assertions that tie saturation to op 8 take them for granted. The stimulus therefore draws `op_i` only from 0 to 8. It mixes random operands with repeated most-negative, most-positive and all-ones element patterns, so that both the saturation case and the rounding ties occur.

// File: rtl/lane_mul_pkg.sv
package lane_mul_pkg;
  localparam int unsigned LANE_W  = 64;
  localparam int unsigned LANE_B  = LANE_W / 8;
  localparam int unsigned NUM_EW  = 4;

  typedef enum logic [3:0] {
    OP_MUL    = 4'd0,
    OP_MULH   = 4'd1,
    OP_MULHU  = 4'd2,
    OP_MULHSU = 4'd3,
    OP_MACC   = 4'd4,
    OP_MADD   = 4'd5,
    OP_NMSAC  = 4'd6,
    OP_NMSUB  = 4'd7,
    OP_FRAC   = 4'd8
  } mul_op_e;

  typedef struct packed {
    logic [LANE_W-1:0] res;
    logic [LANE_B-1:0] mask;
    logic [LANE_B-1:0] sat;
  } lane_out_t;
endpackage

// File: rtl/lane_mul_elem.sv
module lane_mul_elem import lane_mul_pkg::*; #(
  parameter int unsigned W     = 8,
  parameter bit          FIXPT = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  mul_op_e      op_i,
  input  logic [1:0]   rm_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] EMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] EMAX = ~EMIN;

  logic               sgn_a, sgn_b, swap, rbit, ovf;
  logic [W-1:0]       m2, addend, lo, hi, frac_q;
  logic signed [W:0]  xa, xb;
  logic signed [2*W-1:0] prod;

  always_comb begin
    sgn_a  = op_i inside {OP_MULH, OP_MULHSU, OP_FRAC};
    sgn_b  = op_i inside {OP_MULH, OP_FRAC};
    swap   = op_i inside {OP_MADD, OP_NMSUB};
    m2     = swap ? c_i : b_i;
    addend = swap ? b_i : c_i;
    xa     = {sgn_a & a_i[W-1], a_i};
    xb     = {sgn_b & m2[W-1], m2};
    prod   = (2*W)'(xa) * (2*W)'(xb);
    lo     = prod[W-1:0];
    hi     = prod[2*W-1:W];
    // rounding increment on the bits below the kept window
    unique case (rm_i)
      2'b00:   rbit = prod[W-2];
      2'b01:   rbit = prod[W-2] & ((|prod[W-3:0]) | prod[W-1]);
      2'b10:   rbit = 1'b0;
      default: rbit = ~prod[W-1] & (|prod[W-2:0]);
    endcase
    frac_q = prod[2*W-2:W-1] + {{(W-1){1'b0}}, rbit};
    ovf    = FIXPT && (a_i == EMIN) && (b_i == EMIN);
    sat_o  = ovf && (op_i == OP_FRAC);
    unique case (op_i)
      OP_MULH, OP_MULHU, OP_MULHSU: res_o = hi;
      OP_MACC, OP_MADD:             res_o = addend + lo;
      OP_NMSAC, OP_NMSUB:           res_o = addend - lo;
      OP_FRAC:                      res_o = ovf ? EMAX : frac_q;
      default:                      res_o = lo;
    endcase
  end

  always_comb begin
    if (sat_o) begin
      // R7
      sat_max_chk: assert (res_o == EMAX);
    end
    if (op_i != OP_FRAC) begin
      // R7
      sat_only_frac_chk: assert (!sat_o);
    end
  end
endmodule

// File: rtl/lane_mul_stage.sv
module lane_mul_stage #(
  parameter int unsigned DW = 80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] dat_i,
  output logic          rdy_o,
  output logic          vld_o,
  output logic [DW-1:0] dat_o,
  input  logic          rdy_i
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign rdy_o = !vld_q || rdy_i;
  assign vld_o = vld_q;
  assign dat_o = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= 1'b0;
    else if (rdy_o) vld_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (rdy_o) dat_q <= dat_i;
  end

  // R10
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !rdy_i) |=> (vld_o && $stable(dat_o)));

  // R10
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(vld_i));
endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul import lane_mul_pkg::*; #(
  parameter int unsigned STAGES = 2,
  parameter bit          FIXPT  = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic [63:0] c_i,
  input  logic [7:0]  mask_i,
  input  logic [3:0]  op_i,
  input  logic [1:0]  ew_i,
  input  logic [1:0]  rm_i,
  input  logic        valid_i,
  output logic        ready_o,
  output logic [63:0] result_o,
  output logic [7:0]  mask_o,
  output logic [7:0]  sat_o,
  output logic        valid_o,
  input  logic        ready_i
);
  localparam int unsigned DW = $bits(lane_out_t);

  mul_op_e op_e;
  assign op_e = mul_op_e'(op_i);

  logic [NUM_EW-1:0][LANE_W-1:0] res_w;
  logic [NUM_EW-1:0][LANE_B-1:0] sat_w;

  for (genvar k = 0; k < NUM_EW; k++) begin : g_w
    localparam int unsigned W = 8 << k;
    localparam int unsigned N = LANE_W / W;
    for (genvar e = 0; e < N; e++) begin : g_e
      logic s;
      lane_mul_elem #(.W(W), .FIXPT(FIXPT)) u_elem (
        .a_i  (a_i[e*W +: W]),
        .b_i  (b_i[e*W +: W]),
        .c_i  (c_i[e*W +: W]),
        .op_i (op_e),
        .rm_i (rm_i),
        .res_o(res_w[k][e*W +: W]),
        .sat_o(s)
      );
      assign sat_w[k][e*(W/8) +: W/8] = {(W/8){s}};
    end
  end

  logic [STAGES:0]         vld, rdy;
  logic [STAGES:0][DW-1:0] dat;
  lane_out_t               stage_in, stage_out;

  always_comb begin
    stage_in.res  = res_w[ew_i];
    stage_in.mask = mask_i;
    stage_in.sat  = sat_w[ew_i] & mask_i;
  end

  assign vld[0]      = valid_i;
  assign dat[0]      = stage_in;
  assign ready_o     = rdy[0];
  assign rdy[STAGES] = ready_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    lane_mul_stage #(.DW(DW)) u_stg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld[i]),
      .dat_i (dat[i]),
      .rdy_o (rdy[i]),
      .vld_o (vld[i+1]),
      .dat_o (dat[i+1]),
      .rdy_i (rdy[i+1])
    );
  end

  assign stage_out = dat[STAGES];
  assign valid_o   = vld[STAGES];
  assign result_o  = stage_out.res;
  assign mask_o    = stage_out.mask;
  assign sat_o     = stage_out.sat;

  // R7
  sat_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((sat_o & ~mask_o) == '0));

  // R10
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ready_o);
endmodule

// File: tb/simd_lane_mul_tb_top.sv
module simd_lane_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a_i = '0, b_i = '0, c_i = '0;
  logic [7:0]  mask_i = '0;
  logic [3:0]  op_i = '0;
  logic [1:0]  ew_i = '0, rm_i = '0;
  logic        valid_i = 1'b0, ready_i = 1'b0;
  logic        ready_o, valid_o;
  logic [63:0] result_o;
  logic [7:0]  mask_o, sat_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_mul #(.STAGES(STAGES), .FIXPT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .mask_i(mask_i), .op_i(op_i), .ew_i(ew_i), .rm_i(rm_i),
    .valid_i(valid_i), .ready_o(ready_o), .result_o(result_o),
    .mask_o(mask_o), .sat_o(sat_o), .valid_o(valid_o), .ready_i(ready_i)
  );

  typedef struct {
    logic [63:0] res;
    logic [7:0]  msk;
    logic [7:0]  sat;
    logic [3:0]  op;
    int          cyc;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          lat_on = 1'b0, done = 1'b0;
  bit          prev_stall = 1'b0;
  logic [63:0] prev_res;
  logic [7:0]  prev_msk, prev_sat;

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:                   return "R1 R2";
      4'd1, 4'd2, 4'd3:       return "R1 R3";
      4'd4, 4'd6:             return "R1 R4";
      4'd5, 4'd7:             return "R1 R5";
      4'd8:                   return "R1 R6";
      default:                return "R1";
    endcase
  endfunction

  function automatic logic signed [129:0] sx(input logic [63:0] x, input int w, input bit sgn);
    logic signed [129:0] v;
    v = $signed({66'b0, x});
    if (sgn && x[w-1]) v = v - (130'sd1 <<< w);
    return v;
  endfunction

  // behavioural reference: returns {result, sat}
  function automatic logic [71:0] ref_calc(input logic [63:0] a, b, c, input logic [3:0] op,
                                           input logic [1:0] ew, rm, input logic [7:0] msk);
    int w, n;
    logic [63:0] res;
    logic [7:0]  sat;
    w = 8 << ew;
    n = 8 >> ew;
    res = '0;
    sat = '0;
    for (int e = 0; e < n; e++) begin
      logic [63:0] wm, ea, eb, ec, r, mn;
      logic signed [129:0] sa, sb, p, sh;
      logic [129:0] drop, half;
      bit rb, s;
      wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      mn = 64'd1 << (w - 1);
      ea = (a >> (e*w)) & wm;
      eb = (b >> (e*w)) & wm;
      ec = (c >> (e*w)) & wm;
      s  = 1'b0;
      sa = sx(ea, w, op == 4'd1 || op == 4'd3 || op == 4'd8);
      sb = sx((op == 4'd5 || op == 4'd7) ? ec : eb, w, op == 4'd1 || op == 4'd8);
      p  = sa * sb;
      case (op)
        4'd1, 4'd2, 4'd3: r = 64'(p >>> w) & wm;
        4'd4: r = (ec + p[63:0]) & wm;
        4'd5: r = (eb + p[63:0]) & wm;
        4'd6: r = (ec - p[63:0]) & wm;
        4'd7: r = (eb - p[63:0]) & wm;
        4'd8: begin
          if (ea == mn && eb == mn) begin
            r = mn - 64'd1;
            s = 1'b1;
          end else begin
            sh   = p >>> (w - 1);
            drop = 130'(p) & ((130'd1 << (w - 1)) - 130'd1);
            half = 130'd1 << (w - 2);
            case (rm)
              2'd0: rb = (drop >= half);
              2'd1: rb = (drop > half) || (drop == half && sh[0]);
              2'd2: rb = 1'b0;
              default: rb = (drop != 0) && !sh[0];
            endcase
            sh = sh + (rb ? 130'sd1 : 130'sd0);
            r  = sh[63:0] & wm;
          end
        end
        default: r = p[63:0] & wm;
      endcase
      res = res | (r << (e*w));
      if (s)
        for (int j = 0; j < w/8; j++)
          if (msk[e*(w/8)+j]) sat[e*(w/8)+j] = 1'b1;
    end
    return {res, sat};
  endfunction

  function automatic logic [63:0] rep(input logic [1:0] ew, input logic [63:0] pat);
    logic [63:0] v;
    int w;
    w = 8 << ew;
    v = '0;
    for (int e = 0; e < 8 >> ew; e++) v = v | ((pat & ((w == 64) ? '1 : ((64'd1 << w) - 1))) << (e*w));
    return v;
  endfunction

  function automatic logic [63:0] rnd_opnd(input logic [1:0] ew);
    int w;
    w = 8 << ew;
    case ($urandom % 5)
      0: return rep(ew, 64'd1 << (w - 1));
      1: return rep(ew, (64'd1 << (w - 1)) - 64'd1);
      2: return '1;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic observe();
    if (prev_stall) begin
      check(valid_o && result_o == prev_res && mask_o == prev_msk && sat_o == prev_sat,
            "R10", "stall hold", result_o, prev_res);
    end
    if (valid_o && ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected output", result_o, 64'd0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check(result_o == x.res, tag_of(x.op), "result", result_o, x.res);
        check(mask_o == x.msk, "R8", "mask", {56'd0, mask_o}, {56'd0, x.msk});
        check(sat_o == x.sat, "R7", "sat", {56'd0, sat_o}, {56'd0, x.sat});
        if (lat_on)
          check(cyc - x.cyc == STAGES, "R9", "latency", 64'(cyc - x.cyc), 64'(STAGES));
      end
    end
    if (valid_i && ready_o) begin
      exp_t x;
      logic [71:0] r;
      r = ref_calc(a_i, b_i, c_i, op_i, ew_i, rm_i, mask_i);
      x.res = r[71:8];
      x.sat = r[7:0];
      x.msk = mask_i;
      x.op  = op_i;
      x.cyc = cyc;
      exp_q.push_back(x);
    end
    prev_stall = valid_o && !ready_i;
    prev_res   = result_o;
    prev_msk   = mask_o;
    prev_sat   = sat_o;
  endtask

  task automatic step(input bit v, input bit rdy, input logic [63:0] a, b, c,
                      input logic [3:0] op, input logic [1:0] ew, rm, input logic [7:0] msk);
    @(negedge clk);
    valid_i = v; ready_i = rdy; a_i = a; b_i = b; c_i = c;
    op_i = op; ew_i = ew; rm_i = rm; mask_i = msk;
    #(CLK_PERIOD/4);
    cyc++;
    observe();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog expired: actual %0d expected 0", cyc);
    finish_run();
  end

  initial begin
    // R11: reset holds pipeline empty
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R11", "valid during reset", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && ready_o == 1'b1, "R11", "idle after reset",
          {62'd0, valid_o, ready_o}, 64'd1);

    // directed, back-to-back with ready high: latency and throughput (R9)
    lat_on = 1'b1;
    for (int rm = 0; rm < 4; rm++) begin
      // R6 ties: 0.5 * 1 LSB in each byte
      step(1, 1, rep(0, 64'h40), rep(0, 64'h01), '0, 4'd8, 2'd0, 2'(rm), 8'hFF);
      step(1, 1, rep(0, 64'h60), rep(0, 64'h01), '0, 4'd8, 2'd0, 2'(rm), 8'hFF);
      step(1, 1, rep(1, 64'h7123), rep(1, 64'h8765), '0, 4'd8, 2'd1, 2'(rm), 8'hFF);
    end
    for (int ew = 0; ew < 4; ew++) begin
      // R7: most-negative squared, partial mask
      step(1, 1, rep(2'(ew), 64'd1 << ((8 << ew) - 1)), rep(2'(ew), 64'd1 << ((8 << ew) - 1)),
           '0, 4'd8, 2'(ew), 2'd0, 8'h0F);
      step(1, 1, '1, '1, '0, 4'd1, 2'(ew), 2'd0, 8'hFF);
      step(1, 1, '1, '1, '0, 4'd2, 2'(ew), 2'd0, 8'hFF);
      step(1, 1, '1, '1, '0, 4'd3, 2'(ew), 2'd0, 8'hFF);
      step(1, 1, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F0F0F0F0F0F0F0F, 4'd0, 2'(ew), 2'd0, 8'h5A);
      for (int op = 4; op < 8; op++)
        step(1, 1, 64'h1122334455667788, 64'h8877665544332211, 64'h0102030405060708,
             4'(op), 2'(ew), 2'd0, 8'hA5);
    end
    for (int k = 0; k < STAGES + 1; k++) begin
      step(0, 1, '0, '0, '0, 4'd0, 2'd0, 2'd0, 8'h00);
      // R9: stream fully drained, one accept per cycle kept
      check(ready_o == 1'b1, "R9", "ready while streaming", {63'd0, ready_o}, 64'd1);
    end
    lat_on = 1'b0;

    // random traffic with stalls on both sides (R10)
    for (int t = 0; t < 3000; t++) begin
      logic [1:0] ew;
      ew = 2'($urandom % 4);
      step(($urandom % 4) != 0, ($urandom % 10) < 7, rnd_opnd(ew), rnd_opnd(ew), rnd_opnd(ew),
           4'($urandom % 9), ew, 2'($urandom % 4), 8'($urandom));
    end

    for (int k = 0; k < 50 && exp_q.size() != 0; k++)
      step(0, 1, '0, '0, '0, 4'd0, 2'd0, 2'd0, 8'h00);
    // R10: nothing left undelivered
    check(exp_q.size() == 0, "R10", "undelivered ops", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule